// File: doc/BRIEF.md
# Disk Interface Task-File Register Block

This block is the device-side register file of a parallel disk interface. A host-facing strobe interface selects one of four register codes and either reads or writes a byte. Reads return the drive status byte (through a primary or a secondary address) or one of the two cylinder/address bytes. Writes either load a cylinder/address byte or issue a command code. A command write starts execution at once: the block raises a one-cycle start pulse toward the drive core and carries the code with it.

The block keeps the busy, data-request and error state and a pending-interrupt flag. It drives the interrupt line toward the host. The drive core signals completion with a single-cycle strobe and supplies the address it finished on. That address is written into the cylinder registers. In linear block mode these bytes are address bits 23:16 and 15:8. In cylinder/head/sector mode they are the two bytes of a 16-bit cylinder number, which is range-checked against a configured cylinder count.

The two status read paths differ in one way. A primary status read acknowledges the interrupt. A secondary status read returns the same byte and leaves the interrupt pending.

Top module: `ata_taskfile_regs`

## Requirements
- R1: The status byte is, from bit 7 to bit 0: busy, ready, fault, seek-complete, data-request, corrected, index, error. Fault, seek-complete, corrected and index come live from the core inputs.
- R2: A read at select code 6 returns the same byte as the primary status read. It leaves the pending interrupt and the interrupt line unchanged.
- R3: A read at select code 7 returns the status byte and clears the pending interrupt. The interrupt line drops in that same cycle. If an accepted completion arrives in the same cycle, the interrupt stays set.
- R4: A completion strobe while busy clears busy and sets the pending interrupt from the next cycle on. A completion strobe while not busy has no effect.
- R5: A write at select code 7 while not busy is a command write. In the next cycle it gives a one-cycle start pulse carrying the written code. It sets busy and clears data-request, error and the pending interrupt.
- R6: A write at select code 7 while busy is ignored. It gives no start pulse and changes no state.
- R7: Writes at select codes 4 (low byte) and 5 (high byte) update the cylinder registers when not busy. They are ignored while busy.
- R8: On an accepted completion in linear mode, the high register takes address bits 23:16 and the low register takes bits 15:8.
- R9: On an accepted completion in cylinder mode, a cylinder number (address bits 15:0) below the cylinder count is loaded: bits 15:8 go to the high register and bits 7:0 to the low register.
- R10: On an accepted completion in cylinder mode, a cylinder number at or above the cylinder count sets error and leaves both cylinder registers unchanged.
- R11: A data-request strobe from the core sets the data-request bit. A command write clears it.
- R12: After reset, busy, error, data-request and the pending interrupt are clear, ready is set, and both cylinder registers are zero. The status byte then reads 0x40 with the live core bits low.
- R13: Reads at select codes 0 to 3 return zero. Writes at codes 0 to 3 and at code 6 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_rd_stb | input | 1 | Host read strobe, one per cycle |
| host_wr_stb | input | 1 | Host write strobe, one per cycle |
| host_sel | input | 3 | Register select code |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Read byte for the selected register (combinational) |
| intrq | output | 1 | Interrupt line to the host |
| lba_mode | input | 1 | 1 = linear block addressing, 0 = cylinder addressing |
| cmd_start | output | 1 | One-cycle command start pulse to the core |
| cmd_code | output | 8 | Command code of the last accepted command |
| core_done | input | 1 | Completion strobe from the core |
| core_addr | input | 24 | Final address reported at completion |
| core_drq_set | input | 1 | Core request to set data-request |
| core_fault | input | 1 | Live fault status bit |
| core_seek_done | input | 1 | Live seek-complete status bit |
| core_corrected | input | 1 | Live corrected-data status bit |
| core_index | input | 1 | Live index status bit |

## Verification
The bench targets the two status read paths. A design that also acknowledges on the secondary read would drop the interrupt line. A design that clears the flag only a cycle late would leave the line high during the primary read. It also drives a completion in the same cycle as a primary status read, where the wrong priority loses the interrupt. Host writes to the cylinder and command addresses are issued while busy: a design without busy gating would corrupt the reported address or emit a second start pulse. The cylinder-mode completions cover the last legal cylinder and the first illegal one, which catches an off-by-one in the range compare. A design that updated the registers on an out-of-range cylinder would be caught by the read-back that follows.

// File: rtl/ata_tf_pkg.sv
// Shared select codes and status byte layout for the task-file register block.
package ata_tf_pkg;

    localparam logic [2:0] SEL_CYL_LO   = 3'd4;
    localparam logic [2:0] SEL_CYL_HI   = 3'd5;
    localparam logic [2:0] SEL_ALT_STAT = 3'd6;
    localparam logic [2:0] SEL_STAT_CMD = 3'd7;

    localparam int ADDR_W = 24;
    localparam int BYTE_W = 8;

    // Status byte, most significant field first (bit 7 down to bit 0).
    typedef struct packed {
        logic busy;
        logic ready;
        logic fault;
        logic seek_done;
        logic xfer_req;
        logic corrected;
        logic index;
        logic error;
    } stat_byte_t;

endpackage

// File: rtl/ata_tf_decode.sv
// Host strobe decoder: turns read/write strobes and a select code into
// one-hot register operations. Assumes at most one strobe per cycle.
module ata_tf_decode
    import ata_tf_pkg::*;
(
    input  logic       rd_stb,
    input  logic       wr_stb,
    input  logic [2:0] sel,
    output logic       rd_stat,
    output logic       wr_cmd,
    output logic       wr_lo,
    output logic       wr_hi
);

    // Decode the four register operations the rest of the block acts on.
    always_comb begin
        rd_stat = rd_stb && (sel == SEL_STAT_CMD);
        wr_cmd  = wr_stb && (sel == SEL_STAT_CMD);
        wr_lo   = wr_stb && (sel == SEL_CYL_LO);
        wr_hi   = wr_stb && (sel == SEL_CYL_HI);
    end

endmodule

// File: rtl/ata_tf_status.sv
// Status and command control: holds busy, data-request, error and the
// pending interrupt, accepts command writes while idle and completions
// while busy. Assumes core_done is a single-cycle strobe.
module ata_tf_status
    import ata_tf_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_stat,
    input  logic              wr_cmd,
    input  logic [BYTE_W-1:0] cmd_byte,
    input  logic              core_done,
    input  logic              chs_ok,
    input  logic              core_drq_set,
    input  logic              core_fault,
    input  logic              core_seek_done,
    input  logic              core_corrected,
    input  logic              core_index,
    output stat_byte_t        status,
    output logic              intr_pend,
    output logic              busy,
    output logic              cmd_start,
    output logic [BYTE_W-1:0] cmd_code,
    output logic              done_acc
);

    logic              busy_q, drq_q, err_q, intr_q, start_q;
    logic [BYTE_W-1:0] code_q;
    logic              cmd_acc;

    // Qualify command writes and completions by the busy state.
    always_comb begin
        cmd_acc  = wr_cmd && !busy_q;
        done_acc = core_done && busy_q;
    end

    // Busy: set by an accepted command, cleared by an accepted completion.
    always_ff @(posedge clk) begin
        if (!rst_n)        busy_q <= 1'b0;
        else if (cmd_acc)  busy_q <= 1'b1;
        else if (done_acc) busy_q <= 1'b0;
    end

    // Data-request: set on core request, cleared by a new command.
    always_ff @(posedge clk) begin
        if (!rst_n)            drq_q <= 1'b0;
        else if (cmd_acc)      drq_q <= 1'b0;
        else if (core_drq_set) drq_q <= 1'b1;
    end

    // Error: set on an out-of-range completion, cleared by a new command.
    always_ff @(posedge clk) begin
        if (!rst_n)                    err_q <= 1'b0;
        else if (cmd_acc)              err_q <= 1'b0;
        else if (done_acc && !chs_ok)  err_q <= 1'b1;
    end

    // Pending interrupt: a completion wins over an acknowledge in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)                  intr_q <= 1'b0;
        else if (done_acc)           intr_q <= 1'b1;
        else if (cmd_acc || rd_stat) intr_q <= 1'b0;
    end

    // Start pulse and code register toward the drive core.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_q <= 1'b0;
            code_q  <= '0;
        end else begin
            start_q <= cmd_acc;
            if (cmd_acc) code_q <= cmd_byte;
        end
    end

    // Assemble the status byte from held state and live core bits.
    always_comb begin
        status.busy      = busy_q;
        status.ready     = 1'b1;
        status.fault     = core_fault;
        status.seek_done = core_seek_done;
        status.xfer_req  = drq_q;
        status.corrected = core_corrected;
        status.index     = core_index;
        status.error     = err_q;
    end

    assign intr_pend = intr_q;
    assign busy      = busy_q;
    assign cmd_start = start_q;
    assign cmd_code  = code_q;

endmodule

// File: rtl/ata_tf_cyl.sv
// Cylinder/address byte registers: one byte lane per register, loaded by the
// host while idle or by an accepted completion. Assumes CYL_W is a multiple
// of 8 and that the linear address bytes sit directly above the low byte.
module ata_tf_cyl
    import ata_tf_pkg::*;
#(
    parameter int NUM_CYL = 16383,
    parameter int CYL_W   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              busy,
    input  logic              done_acc,
    input  logic              lba_mode,
    input  logic [ADDR_W-1:0] core_addr,
    output logic              chs_ok,
    output logic [BYTE_W-1:0] cyl_lo,
    output logic [BYTE_W-1:0] cyl_hi
);

    localparam int LANES = CYL_W / BYTE_W;
    localparam logic [CYL_W:0] CYL_LIMIT = (CYL_W + 1)'(NUM_CYL);

    logic [LANES-1:0]             lane_wr;
    logic [LANES-1:0][BYTE_W-1:0] lane_q;
    logic [CYL_W-1:0]             cyl_num;

    // Range check of the reported cylinder; linear addresses are always taken.
    always_comb begin
        cyl_num = core_addr[CYL_W-1:0];
        chs_ok  = lba_mode || ({1'b0, cyl_num} < CYL_LIMIT);
    end

    assign lane_wr = {wr_hi, wr_lo};

    generate
        for (genvar i = 0; i < LANES; i++) begin : g_lane
            logic [BYTE_W-1:0] load_val;

            // Pick the completion byte for this lane by addressing mode.
            always_comb begin
                if (lba_mode) load_val = core_addr[BYTE_W*(i+1) +: BYTE_W];
                else          load_val = core_addr[BYTE_W*i +: BYTE_W];
            end

            // Lane register: completion load, or host write while idle.
            always_ff @(posedge clk) begin
                if (!rst_n)                    lane_q[i] <= '0;
                else if (done_acc && chs_ok)   lane_q[i] <= load_val;
                else if (lane_wr[i] && !busy)  lane_q[i] <= wdata;
            end
        end
    endgenerate

    assign cyl_lo = lane_q[0];
    assign cyl_hi = lane_q[LANES-1];

endmodule

// File: rtl/ata_taskfile_regs.sv
// Top of the task-file register block: host strobe decode, status/command
// control, cylinder registers and the read multiplexer. Read data is
// combinational on the select code; the interrupt line is masked during a
// primary status read so the acknowledge is visible in the same cycle.
module ata_taskfile_regs
    import ata_tf_pkg::*;
#(
    parameter int NUM_CYL = 16383
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_rd_stb,
    input  logic              host_wr_stb,
    input  logic [2:0]        host_sel,
    input  logic [7:0]        host_wdata,
    output logic [7:0]        host_rdata,
    output logic              intrq,
    input  logic              lba_mode,
    output logic              cmd_start,
    output logic [7:0]        cmd_code,
    input  logic              core_done,
    input  logic [23:0]       core_addr,
    input  logic              core_drq_set,
    input  logic              core_fault,
    input  logic              core_seek_done,
    input  logic              core_corrected,
    input  logic              core_index
);

    logic       rd_stat, wr_cmd, wr_lo, wr_hi;
    logic       chs_ok, busy, done_acc, intr_pend;
    stat_byte_t status;
    logic [7:0] cyl_lo, cyl_hi;

    ata_tf_decode u_decode (
        .rd_stb  (host_rd_stb),
        .wr_stb  (host_wr_stb),
        .sel     (host_sel),
        .rd_stat (rd_stat),
        .wr_cmd  (wr_cmd),
        .wr_lo   (wr_lo),
        .wr_hi   (wr_hi)
    );

    ata_tf_status u_status (
        .clk            (clk),
        .rst_n          (rst_n),
        .rd_stat        (rd_stat),
        .wr_cmd         (wr_cmd),
        .cmd_byte       (host_wdata),
        .core_done      (core_done),
        .chs_ok         (chs_ok),
        .core_drq_set   (core_drq_set),
        .core_fault     (core_fault),
        .core_seek_done (core_seek_done),
        .core_corrected (core_corrected),
        .core_index     (core_index),
        .status         (status),
        .intr_pend      (intr_pend),
        .busy           (busy),
        .cmd_start      (cmd_start),
        .cmd_code       (cmd_code),
        .done_acc       (done_acc)
    );

    ata_tf_cyl #(
        .NUM_CYL (NUM_CYL),
        .CYL_W   (16)
    ) u_cyl (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_lo     (wr_lo),
        .wr_hi     (wr_hi),
        .wdata     (host_wdata),
        .busy      (busy),
        .done_acc  (done_acc),
        .lba_mode  (lba_mode),
        .core_addr (core_addr),
        .chs_ok    (chs_ok),
        .cyl_lo    (cyl_lo),
        .cyl_hi    (cyl_hi)
    );

    // Read multiplexer; unused select codes read as zero.
    always_comb begin
        case (host_sel)
            SEL_STAT_CMD, SEL_ALT_STAT: host_rdata = status;
            SEL_CYL_LO:                 host_rdata = cyl_lo;
            SEL_CYL_HI:                 host_rdata = cyl_hi;
            default:                    host_rdata = '0;
        endcase
    end

    // Interrupt line, dropped immediately by a primary status read.
    assign intrq = intr_pend && !rd_stat;

endmodule

// File: rtl/ata_taskfile_regs_chk.sv
// Property checker for the task-file register block, bound to the top.
module ata_taskfile_regs_chk
    import ata_tf_pkg::*;
#(
    parameter int NUM_CYL = 16383
) (
    input logic        clk,
    input logic        rst_n,
    input logic        host_rd_stb,
    input logic        host_wr_stb,
    input logic [2:0]  host_sel,
    input logic [7:0]  host_rdata,
    input logic        intrq,
    input logic        lba_mode,
    input logic        cmd_start,
    input logic        core_done,
    input logic [23:0] core_addr,
    input logic        busy,
    input logic        intr_pend,
    input logic        err,
    input logic [7:0]  cyl_lo,
    input logic [7:0]  cyl_hi
);

    AST_STAT_READ_ACKS: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd_stb && host_sel == SEL_STAT_CMD && !(core_done && busy)) |=> !intr_pend) // R3
        else $error("status read did not acknowledge");

    AST_ALT_READ_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd_stb && host_sel == SEL_ALT_STAT && !host_wr_stb && intrq) |=> intr_pend) // R2
        else $error("secondary status read cleared interrupt");

    AST_DONE_RAISES_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (core_done && busy) |=> (!busy && intr_pend)) // R4
        else $error("completion did not raise interrupt");

    AST_CMD_LAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr_stb && host_sel == SEL_STAT_CMD && !busy) |=> (busy && cmd_start && !err)) // R5
        else $error("command write not launched");

    AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_start |=> !cmd_start) // R5
        else $error("start pulse longer than one cycle");

    AST_BUSY_CMD_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr_stb && host_sel == SEL_STAT_CMD && busy) |=> !cmd_start) // R6
        else $error("command accepted while busy");

    AST_BUSY_CYL_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !core_done) |=> ($stable(cyl_lo) && $stable(cyl_hi))) // R7
        else $error("cylinder registers changed while busy");

    AST_LBA_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (core_done && busy && lba_mode) |=>
            (cyl_hi == $past(core_addr[23:16]) && cyl_lo == $past(core_addr[15:8]))) // R8
        else $error("linear completion address not loaded");

    AST_CHS_RANGE_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (core_done && busy && !lba_mode && int'(core_addr[15:0]) >= NUM_CYL) |=>
            (err && $stable(cyl_lo) && $stable(cyl_hi))) // R10
        else $error("out-of-range cylinder accepted");

    AST_READY_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd_stb && host_sel == SEL_STAT_CMD) |-> host_rdata[6]) // R1
        else $error("ready bit low");

endmodule

bind ata_taskfile_regs ata_taskfile_regs_chk #(.NUM_CYL(NUM_CYL)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .host_rd_stb (host_rd_stb),
    .host_wr_stb (host_wr_stb),
    .host_sel    (host_sel),
    .host_rdata  (host_rdata),
    .intrq       (intrq),
    .lba_mode    (lba_mode),
    .cmd_start   (cmd_start),
    .core_done   (core_done),
    .core_addr   (core_addr),
    .busy        (busy),
    .intr_pend   (intr_pend),
    .err         (status.error),
    .cyl_lo      (cyl_lo),
    .cyl_hi      (cyl_hi)
);

// File: tb/tb_ata_taskfile_regs.sv
`timescale 1ns/1ps
module tb_ata_taskfile_regs;

    localparam int NCYL = 1000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rd = 1'b0, wr = 1'b0;
    logic [2:0]  sel = '0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;
    logic        intrq;
    logic        lba = 1'b0;
    logic        cmd_start;
    logic [7:0]  cmd_code;
    logic        done = 1'b0;
    logic [23:0] caddr = '0;
    logic        drqset = 1'b0;
    logic        df = 1'b0, dsc = 1'b0, cor = 1'b0, idx = 1'b0;

    int total = 0;
    int bad = 0;

    // Behavioural reference state.
    bit        m_bsy, m_intr, m_err, m_drq, m_start;
    bit [7:0]  m_code, m_lo, m_hi;

    always #4 clk = ~clk;

    ata_taskfile_regs #(.NUM_CYL(NCYL)) dut (
        .clk(clk), .rst_n(rst_n), .host_rd_stb(rd), .host_wr_stb(wr),
        .host_sel(sel), .host_wdata(wdata), .host_rdata(rdata), .intrq(intrq),
        .lba_mode(lba), .cmd_start(cmd_start), .cmd_code(cmd_code),
        .core_done(done), .core_addr(caddr), .core_drq_set(drqset),
        .core_fault(df), .core_seek_done(dsc), .core_corrected(cor), .core_index(idx)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    function automatic bit [7:0] m_status();
        return {m_bsy, 1'b1, df, dsc, m_drq, cor, idx, m_err};
    endfunction

    function automatic bit [7:0] m_read(input bit [2:0] s);
        case (s)
            3'd7, 3'd6: return m_status();
            3'd4:       return m_lo;
            3'd5:       return m_hi;
            default:    return 8'h00;
        endcase
    endfunction

    // One clock: compare against the model, then advance the model.
    task automatic cyc();
        bit acc_cmd, acc_done, ok;
        #1;
        chk("R3 intrq", intrq, m_intr && !(rd && sel == 3'd7));
        chk("R5 cmd_start", cmd_start, m_start);
        if (m_start) chk("R5 cmd_code", cmd_code, m_code);
        if (rd) chk("R13 rdata", rdata, m_read(sel));
        @(posedge clk);
        acc_cmd  = wr && sel == 3'd7 && !m_bsy;
        acc_done = done && m_bsy;
        ok       = lba || (int'(caddr[15:0]) < NCYL);
        if (wr && !m_bsy && sel == 3'd4) m_lo = wdata;
        if (wr && !m_bsy && sel == 3'd5) m_hi = wdata;
        if (acc_done && ok) begin
            m_hi = lba ? caddr[23:16] : caddr[15:8];
            m_lo = lba ? caddr[15:8]  : caddr[7:0];
        end
        if (drqset) m_drq = 1;
        if (acc_cmd) begin m_drq = 0; m_err = 0; m_intr = 0; m_code = wdata; end
        if (rd && sel == 3'd7) m_intr = 0;
        if (acc_done) begin m_bsy = 0; m_intr = 1; if (!ok) m_err = 1; end
        if (acc_cmd) m_bsy = 1;
        m_start = acc_cmd;
        @(negedge clk);
        rd = 0; wr = 0; done = 0; drqset = 0;
    endtask

    task automatic hwrite(input bit [2:0] s, input bit [7:0] d);
        wr = 1; sel = s; wdata = d; cyc();
    endtask

    task automatic hread(input bit [2:0] s, output bit [7:0] d);
        rd = 1; sel = s; #1 d = rdata; #0 cyc();
    endtask

    task automatic finish_done(input bit l, input bit [23:0] a);
        lba = l; caddr = a; done = 1; cyc();
    endtask

    initial begin
        #1_000_000;
        bad++;
        $display("FAIL watchdog act=timeout exp=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        bit [7:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1;
        m_bsy = 0; m_intr = 0; m_err = 0; m_drq = 0; m_start = 0;
        m_code = 0; m_lo = 0; m_hi = 0;

        // R12 reset values
        hread(3'd7, v); chk("R12 status", v, 8'h40);
        hread(3'd4, v); chk("R12 cyl_lo", v, 8'h00);
        hread(3'd5, v); chk("R12 cyl_hi", v, 8'h00);
        chk("R12 intrq", intrq, 0);

        // R7 host cylinder writes while idle
        hwrite(3'd4, 8'h12); hwrite(3'd5, 8'h34);
        hread(3'd4, v); chk("R7 lo", v, 8'h12);
        hread(3'd5, v); chk("R7 hi", v, 8'h34);

        // R13 unused codes and secondary address writes
        hread(3'd2, v); chk("R13 unused read", v, 8'h00);
        hwrite(3'd6, 8'hFF); hwrite(3'd1, 8'h77);
        chk("R13 no start", cmd_start, 0);
        hread(3'd6, v); chk("R13 status unchanged", v, 8'h40);

        // R1 live bits in place
        df = 1; idx = 1;
        hread(3'd7, v); chk("R1 fault/index", v, 8'h62);
        df = 0; idx = 0; dsc = 1; cor = 1;
        hread(3'd6, v); chk("R1 seek/corrected", v, 8'h54);
        dsc = 0; cor = 0;

        // R11 data-request
        drqset = 1; cyc();
        hread(3'd7, v); chk("R11 drq set", v, 8'h48);

        // R5 command launch
        hwrite(3'd7, 8'hC8);
        #1 chk("R5 start", cmd_start, 1); chk("R5 code", cmd_code, 8'hC8);
        hread(3'd7, v); chk("R5 busy, drq cleared", v, 8'hC0);

        // R7 / R6 ignored while busy
        hwrite(3'd4, 8'h99);
        hread(3'd4, v); chk("R7 busy write ignored", v, 8'h12);
        hwrite(3'd7, 8'h20);
        #1 chk("R6 no start while busy", cmd_start, 0); chk("R6 code kept", cmd_code, 8'hC8);

        // R8 linear completion
        finish_done(1, 24'hABCDEF);
        #1 chk("R4 intrq raised", intrq, 1);
        hread(3'd5, v); chk("R8 hi", v, 8'hAB);
        hread(3'd4, v); chk("R8 lo", v, 8'hCD);

        // R2 secondary read keeps interrupt
        hread(3'd6, v); chk("R2 alt byte", v, 8'h40);
        #1 chk("R2 intrq kept", intrq, 1);

        // R3 primary read clears in the same cycle
        rd = 1; sel = 3'd7; #1 chk("R3 same-cycle drop", intrq, 0); cyc();
        #1 chk("R3 stays low", intrq, 0);

        // R9 cylinder mode, including the last legal cylinder
        hwrite(3'd7, 8'h30); finish_done(0, 24'h000123);
        hread(3'd5, v); chk("R9 hi", v, 8'h01);
        hread(3'd4, v); chk("R9 lo", v, 8'h23);
        hwrite(3'd7, 8'h30); finish_done(0, 24'hFF03E7);
        hread(3'd5, v); chk("R9 edge hi", v, 8'h03);
        hread(3'd4, v); chk("R9 edge lo", v, 8'hE7);

        // R10 first illegal cylinder
        hwrite(3'd7, 8'h30); finish_done(0, 24'h0003E8);
        hread(3'd6, v); chk("R10 error set", v, 8'h41);
        hread(3'd5, v); chk("R10 hi kept", v, 8'h03);
        hread(3'd4, v); chk("R10 lo kept", v, 8'hE7);

        // R5 new command clears error and interrupt
        hwrite(3'd7, 8'h31);
        #1 chk("R5 irq cleared", intrq, 0);
        hread(3'd6, v); chk("R5 error cleared", v, 8'hC0);

        // R3 completion coincident with a primary read
        rd = 1; sel = 3'd7; done = 1; lba = 1; caddr = 24'h112233; cyc();
        #1 chk("R3 completion wins", intrq, 1);
        hread(3'd5, v); chk("R8 hi again", v, 8'h11);

        // R4 completion while idle ignored
        hread(3'd7, v);
        finish_done(1, 24'h555555);
        #1 chk("R4 idle done no irq", intrq, 0);
        hread(3'd4, v); chk("R4 idle done no load", v, 8'h22);

        repeat (4) cyc();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule